// File: doc/BRIEF.md
# NOR Flash Write-Cycle Command Decoder

This block sits on the device side of a parallel NOR flash. It observes every write strobe together with its address, data and the current byte/word organisation, and recognises the unlock-guarded command set. When a sequence completes, it emits a one-clock request pulse to the program/erase engine: program (with address and data), chip erase, sector erase (with sector number), erase suspend or erase resume. It also keeps two mode flags. The read-mode flag selects between array reads and identification reads. The bypass flag marks a mode in which programs skip the unlock cycles.

In identification mode, a combinational read port returns the manufacturer code, the device code, or the protect status of the sector that contains the read address. The flash array, the program/erase timing and the status polling bits are outside this block. Address pins are seen as the device sees them. In word organisation, bit 0 of `addr_i` is A0 and the top bit is unused. In byte organisation, bit 0 is A-1 and the whole vector forms a byte address.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset no request output is high, `autosel_o` is 0, `bypass_o` is 0 and `rd_data_o` is 0.
- R2: A command sequence begins with data AA at pattern P1 and then data 55 at pattern P2. The command byte follows at P1. In word organisation, P1 is A10..A0 = 0x555 and P2 is 0x2AA. In byte organisation (A-1 as LSB), P1 is A10..A-1 = 0xAAA and P2 is 0x555. Address bits above A10 are not compared.
- R3: Command byte A0 arms a program. The next write produces `prog_o` with that write's `addr_i` and data. In byte organisation the data is the low 8 bits with the upper byte zero.
- R4: Command byte 80, then a second AA/55 unlock pair, then data 10 at P1, produces `chip_erase_o`.
- R5: Command byte 80, then a second unlock pair, then data 30 at any address, produces `sect_erase_o`. `sect_o` carries word-address bits A12 and up (byte view: `addr_i[AW:13]`).
- R6: Command byte 90 sets `autosel_o`. Reads then decode the word offset A11..A0: 0 returns 0x0001, 1 returns the device code (0x22DA by default), 2 returns the protect bit of the sector addressed by `rd_addr_i`, and any other offset returns 0. In byte organisation A-1 selects the low (0) or high (1) byte, zero-extended. Outside identification mode `rd_data_o` is 0.
- R7: Data F0 at any address aborts any partial sequence, including an armed program, and clears `autosel_o` without a request. It leaves `bypass_o` unchanged. In identification mode every other write is ignored.
- R8: Command byte 20 sets `bypass_o`. In bypass, data A0 followed by one write issues a program as in R3. Data 90 followed by data 00 clears `bypass_o`, and the unlock pair is ignored.
- R9: When idle with `erase_busy_i` high, data B0 at any address gives `suspend_o` and data 30 gives `resume_o`. With `erase_busy_i` low neither is produced.
- R10: A write that does not match the expected next cycle of a sequence returns the decoder to idle with no request.
- R11: Requests are high for exactly one clock, in the cycle after the completing write, and at most one is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, one cycle per bus write |
| byte_mode_i | input | 1 | 1 = byte organisation, 0 = word organisation |
| addr_i | input | AW+1 | Write address as seen at the device pins |
| data_i | input | 16 | Write data |
| erase_busy_i | input | 1 | Erase in progress or suspended |
| rd_addr_i | input | AW+1 | Read address for identification reads |
| protect_i | input | 2**(AW-12) | Per-sector protect status |
| prog_o | output | 1 | Program request pulse |
| prog_addr_o | output | AW+1 | Program address |
| prog_data_o | output | 16 | Program data |
| chip_erase_o | output | 1 | Chip erase request pulse |
| sect_erase_o | output | 1 | Sector erase request pulse |
| sect_o | output | AW-12 | Sector number for sector erase |
| suspend_o | output | 1 | Erase suspend request pulse |
| resume_o | output | 1 | Erase resume request pulse |
| autosel_o | output | 1 | Identification read mode active |
| bypass_o | output | 1 | Unlock bypass mode active |
| rd_data_o | output | 16 | Identification read data |

## Verification
The hardest cases to reach are the aborted sequences deep in a six-cycle erase. The stimulus builds the first five cycles correctly and then supplies a wrong final byte, or an F0 in place of armed program data. Any pulse that then appears has no queued expectation and is reported. Byte-organisation patterns are exercised separately. So is the pair of unlock addresses with the don't-care bits above A10 set, because only those show whether the A-1 remapping and the truncated compare are right. Bypass entry and exit are driven around suspend/resume traffic with the busy input toggled.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_PROG, ST_ERS1, ST_ERS2, ST_ERS3, ST_BYPX
  } dec_state_e;

  localparam logic [7:0] CMD_KEY1    = 8'hAA;
  localparam logic [7:0] CMD_KEY2    = 8'h55;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_PROG    = 8'hA0;
  localparam logic [7:0] CMD_ERASE   = 8'h80;
  localparam logic [7:0] CMD_BYPASS  = 8'h20;
  localparam logic [7:0] CMD_CHIP    = 8'h10;
  localparam logic [7:0] CMD_SECT    = 8'h30;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;
  localparam logic [7:0] CMD_ABORT   = 8'hF0;
  localparam logic [7:0] CMD_BYPEXIT = 8'h00;
endpackage

// File: rtl/nor_addr_match.sv
module nor_addr_match #(
  parameter int AW = 20
) (
  input  logic [AW:0]      addr_i,
  input  logic             byte_mode_i,
  output logic             hit_p1_o,
  output logic             hit_p2_o,
  output logic [AW-13:0]   sect_o
);
  logic [AW-1:0] wa;
  logic          lsb;
  logic          unused_wa11;

  // normalise to word address; A-1 only meaningful in byte organisation
  assign wa  = byte_mode_i ? addr_i[AW:1] : addr_i[AW-1:0];
  assign lsb = addr_i[0];
  assign unused_wa11 = wa[11];

  assign hit_p1_o = (wa[10:0] == 11'h555) && (!byte_mode_i || !lsb);
  assign hit_p2_o = (wa[10:0] == 11'h2AA) && (!byte_mode_i ||  lsb);
  assign sect_o   = wa[AW-1:12];
endmodule

// File: rtl/nor_ident_read.sv
module nor_ident_read #(
  parameter int          AW     = 20,
  parameter logic [15:0] MFR_ID = 16'h0001,
  parameter logic [15:0] DEV_ID = 16'h22DA,
  localparam int         SW     = AW - 12,
  localparam int         NSECT  = 1 << SW
) (
  input  logic             en_i,
  input  logic             byte_mode_i,
  input  logic [AW:0]      rd_addr_i,
  input  logic [NSECT-1:0] protect_i,
  output logic [15:0]      rd_data_o
);
  logic [AW-1:0] wa;
  logic [15:0]   word;

  assign wa = byte_mode_i ? rd_addr_i[AW:1] : rd_addr_i[AW-1:0];

  always_comb begin
    unique case (wa[11:0])
      12'h000: word = MFR_ID;
      12'h001: word = DEV_ID;
      12'h002: word = {15'd0, protect_i[wa[AW-1:12]]};
      default: word = 16'h0000;
    endcase
    if (!en_i)
      rd_data_o = 16'h0000;
    else if (byte_mode_i)
      rd_data_o = rd_addr_i[0] ? {8'h00, word[15:8]} : {8'h00, word[7:0]};
    else
      rd_data_o = word;
  end
endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_cmd_pkg::*;
#(
  parameter int AW = 20,
  localparam int SW = AW - 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          byte_mode_i,
  input  logic [AW:0]   addr_i,
  input  logic [15:0]   data_i,
  input  logic          hit_p1_i,
  input  logic          hit_p2_i,
  input  logic [SW-1:0] sect_i,
  input  logic          erase_busy_i,
  output logic          prog_o,
  output logic [AW:0]   prog_addr_o,
  output logic [15:0]   prog_data_o,
  output logic          chip_erase_o,
  output logic          sect_erase_o,
  output logic [SW-1:0] sect_o,
  output logic          suspend_o,
  output logic          resume_o,
  output logic          autosel_o,
  output logic          bypass_o
);
  dec_state_e st_q;
  logic [7:0] cmd;
  assign cmd = data_i[7:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      prog_o       <= 1'b0;
      prog_addr_o  <= '0;
      prog_data_o  <= '0;
      chip_erase_o <= 1'b0;
      sect_erase_o <= 1'b0;
      sect_o       <= '0;
      suspend_o    <= 1'b0;
      resume_o     <= 1'b0;
      autosel_o    <= 1'b0;
      bypass_o     <= 1'b0;
    end else begin
      prog_o       <= 1'b0;
      chip_erase_o <= 1'b0;
      sect_erase_o <= 1'b0;
      suspend_o    <= 1'b0;
      resume_o     <= 1'b0;
      if (wr_i) begin
        if (cmd == CMD_ABORT) begin
          st_q      <= ST_IDLE;
          autosel_o <= 1'b0;
        end else if (!autosel_o) begin
          unique case (st_q)
            ST_IDLE: begin
              if (erase_busy_i && cmd == CMD_SUSPEND)  suspend_o <= 1'b1;
              else if (erase_busy_i && cmd == CMD_SECT) resume_o <= 1'b1;
              else if (bypass_o) begin
                if (cmd == CMD_PROG)       st_q <= ST_PROG;
                else if (cmd == CMD_IDENT) st_q <= ST_BYPX;
              end else if (hit_p1_i && cmd == CMD_KEY1) st_q <= ST_UNL1;
            end
            ST_UNL1: st_q <= (hit_p2_i && cmd == CMD_KEY2) ? ST_UNL2 : ST_IDLE;
            ST_UNL2: begin
              st_q <= ST_IDLE;
              if (hit_p1_i) begin
                unique case (cmd)
                  CMD_IDENT:  autosel_o <= 1'b1;
                  CMD_PROG:   st_q      <= ST_PROG;
                  CMD_ERASE:  st_q      <= ST_ERS1;
                  CMD_BYPASS: bypass_o  <= 1'b1;
                  default: ;
                endcase
              end
            end
            ST_PROG: begin
              st_q        <= ST_IDLE;
              prog_o      <= 1'b1;
              prog_addr_o <= addr_i;
              prog_data_o <= byte_mode_i ? {8'h00, data_i[7:0]} : data_i;
            end
            ST_ERS1: st_q <= (hit_p1_i && cmd == CMD_KEY1) ? ST_ERS2 : ST_IDLE;
            ST_ERS2: st_q <= (hit_p2_i && cmd == CMD_KEY2) ? ST_ERS3 : ST_IDLE;
            ST_ERS3: begin
              st_q <= ST_IDLE;
              if (hit_p1_i && cmd == CMD_CHIP) chip_erase_o <= 1'b1;
              else if (cmd == CMD_SECT) begin
                sect_erase_o <= 1'b1;
                sect_o       <= sect_i;
              end
            end
            ST_BYPX: begin
              st_q <= ST_IDLE;
              if (cmd == CMD_BYPEXIT) bypass_o <= 1'b0;
            end
            default: st_q <= ST_IDLE;
          endcase
        end
      end
    end
  end

  assert_req_onehot_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_o, chip_erase_o, sect_erase_o, suspend_o, resume_o}));
  assert_req_after_wr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_o || chip_erase_o || sect_erase_o || suspend_o || resume_o) |-> $past(wr_i));
  assert_mode_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(autosel_o && bypass_o));
  assert_bypass_exit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bypass_o) |-> $past(wr_i && data_i[7:0] == CMD_BYPEXIT));
  assert_susp_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (suspend_o || resume_o) |-> $past(erase_busy_i));
  assert_autosel_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(autosel_o) |-> $past(wr_i && data_i[7:0] == CMD_ABORT));
endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder #(
  parameter int          AW     = 20,
  parameter logic [15:0] MFR_ID = 16'h0001,
  parameter logic [15:0] DEV_ID = 16'h22DA,
  localparam int         SW     = AW - 12,
  localparam int         NSECT  = 1 << SW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             byte_mode_i,
  input  logic [AW:0]      addr_i,
  input  logic [15:0]      data_i,
  input  logic             erase_busy_i,
  input  logic [AW:0]      rd_addr_i,
  input  logic [NSECT-1:0] protect_i,
  output logic             prog_o,
  output logic [AW:0]      prog_addr_o,
  output logic [15:0]      prog_data_o,
  output logic             chip_erase_o,
  output logic             sect_erase_o,
  output logic [SW-1:0]    sect_o,
  output logic             suspend_o,
  output logic             resume_o,
  output logic             autosel_o,
  output logic             bypass_o,
  output logic [15:0]      rd_data_o
);
  logic          hit_p1, hit_p2;
  logic [SW-1:0] wr_sect;

  nor_addr_match #(.AW(AW)) i_match (
    .addr_i      (addr_i),
    .byte_mode_i (byte_mode_i),
    .hit_p1_o    (hit_p1),
    .hit_p2_o    (hit_p2),
    .sect_o      (wr_sect)
  );

  nor_cmd_fsm #(.AW(AW)) i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (wr_i),
    .byte_mode_i  (byte_mode_i),
    .addr_i       (addr_i),
    .data_i       (data_i),
    .hit_p1_i     (hit_p1),
    .hit_p2_i     (hit_p2),
    .sect_i       (wr_sect),
    .erase_busy_i (erase_busy_i),
    .prog_o       (prog_o),
    .prog_addr_o  (prog_addr_o),
    .prog_data_o  (prog_data_o),
    .chip_erase_o (chip_erase_o),
    .sect_erase_o (sect_erase_o),
    .sect_o       (sect_o),
    .suspend_o    (suspend_o),
    .resume_o     (resume_o),
    .autosel_o    (autosel_o),
    .bypass_o     (bypass_o)
  );

  nor_ident_read #(.AW(AW), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) i_ident (
    .en_i        (autosel_o),
    .byte_mode_i (byte_mode_i),
    .rd_addr_i   (rd_addr_i),
    .protect_i   (protect_i),
    .rd_data_o   (rd_data_o)
  );
endmodule

// File: tb/test_nor_cmd_decoder.sv
module test_nor_cmd_decoder;
  localparam int AW = 20;
  localparam int SW = AW - 12;

  typedef struct {
    int          kind;  // 1 prog, 2 chip, 3 sector, 4 suspend, 5 resume
    logic [AW:0] addr;
    logic [15:0] data;
    logic [SW-1:0] sect;
  } ev_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0, byte_m = 1'b0, busy = 1'b0;
  logic [AW:0] addr = '0, rd_addr = '0;
  logic [15:0] data = '0;
  logic [(1<<SW)-1:0] prot = '0;
  logic prog, chip, sect_e, susp, res, autosel, bypass;
  logic [AW:0] prog_addr;
  logic [15:0] prog_data, rd_data;
  logic [SW-1:0] sect;

  int checks = 0, errors = 0;
  ev_t exp_q[$];

  always #5 clk = ~clk;

  nor_cmd_decoder i_nor_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .byte_mode_i(byte_m),
    .addr_i(addr), .data_i(data), .erase_busy_i(busy), .rd_addr_i(rd_addr),
    .protect_i(prot), .prog_o(prog), .prog_addr_o(prog_addr),
    .prog_data_o(prog_data), .chip_erase_o(chip), .sect_erase_o(sect_e),
    .sect_o(sect), .suspend_o(susp), .resume_o(res), .autosel_o(autosel),
    .bypass_o(bypass), .rd_data_o(rd_data)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wr_cyc(input logic [AW:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; data = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic expect_ev(input int k, input logic [AW:0] a, input logic [15:0] d,
                           input logic [SW-1:0] s);
    ev_t e;
    e.kind = k; e.addr = a; e.data = d; e.sect = s;
    exp_q.push_back(e);
  endtask

  // word-view unlock prefix with command byte
  task automatic cmd_word(input logic [7:0] c);
    wr_cyc(21'h00555, 16'h00AA);
    wr_cyc(21'h002AA, 16'h0055);
    wr_cyc(21'h00555, {8'h00, c});
  endtask

  task automatic cmd_byte(input logic [7:0] c);
    wr_cyc(21'h00AAA, 16'h00AA);
    wr_cyc(21'h00555, 16'h0055);
    wr_cyc(21'h00AAA, {8'h00, c});
  endtask

  function automatic string req_of(input int k);
    case (k)
      1: return "R3";
      2: return "R4";
      3: return "R5";
      default: return "R9";
    endcase
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      int n;
      int k;
      n = int'(prog) + int'(chip) + int'(sect_e) + int'(susp) + int'(res);
      k = prog ? 1 : chip ? 2 : sect_e ? 3 : susp ? 4 : res ? 5 : 0;
      if (n > 1) check(1'b0, "R11 multiple requests", n, 1);
      if (n != 0) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 unexpected request kind", k, 0);
        end else begin
          ev_t e;
          e = exp_q.pop_front();
          check(k == e.kind, req_of(e.kind), k, e.kind);
          if (k == 1 && e.kind == 1) begin
            check(prog_addr == e.addr, "R3 addr", prog_addr, e.addr);
            check(prog_data == e.data, "R3 data", prog_data, e.data);
          end
          if (k == 3 && e.kind == 3)
            check(sect == e.sect, "R5 sector", sect, e.sect);
        end
      end
    end
  end

  task automatic drain;
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R11 missing request", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    prot[5] = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!prog && !chip && !sect_e && !susp && !res, "R1 requests", 0, 0);
    check(!autosel && !bypass, "R1 modes", {autosel, bypass}, 0);
    check(rd_data == 16'h0, "R1 rd_data", rd_data, 0);
    rst_n = 1'b1;

    // R3 word program
    cmd_word(8'hA0);
    expect_ev(1, 21'h01234, 16'hBEEF, '0);
    wr_cyc(21'h01234, 16'hBEEF);
    drain();

    // R2 upper address bits don't care
    wr_cyc(21'h07D55, 16'h00AA);
    wr_cyc(21'h13AAA, 16'h0055);
    wr_cyc(21'h0FD55, 16'h00A0);
    expect_ev(1, 21'h00042, 16'h1357, '0);
    wr_cyc(21'h00042, 16'h1357);
    drain();

    // R2 R3 byte organisation, A-1 as LSB, upper data byte dropped
    byte_m = 1'b1;
    cmd_byte(8'hA0);
    expect_ev(1, 21'h00777, 16'h00C3, '0);
    wr_cyc(21'h00777, 16'hFFC3);
    drain();
    // R2 word patterns are not byte patterns
    wr_cyc(21'h00555, 16'h00AA);
    wr_cyc(21'h002AA, 16'h0055);
    wr_cyc(21'h00555, 16'h00A0);
    wr_cyc(21'h00100, 16'h0011);
    drain();

    // R5 byte-view sector erase
    cmd_byte(8'h80);
    wr_cyc(21'h00AAA, 16'h00AA);
    wr_cyc(21'h00555, 16'h0055);
    expect_ev(3, '0, '0, 8'h9C);
    wr_cyc({8'h9C, 13'h0123}, 16'h0030);
    drain();
    byte_m = 1'b0;

    // R4 chip erase
    cmd_word(8'h80);
    wr_cyc(21'h00555, 16'h00AA);
    wr_cyc(21'h002AA, 16'h0055);
    expect_ev(2, '0, '0, '0);
    wr_cyc(21'h00555, 16'h0010);
    drain();

    // R5 word sector erase
    cmd_word(8'h80);
    wr_cyc(21'h00555, 16'h00AA);
    wr_cyc(21'h002AA, 16'h0055);
    expect_ev(3, '0, '0, 8'h47);
    wr_cyc({1'b0, 8'h47, 12'h3F0}, 16'h0030);
    drain();

    // R10 bad final erase byte, bad unlock data, bad command address
    cmd_word(8'h80);
    wr_cyc(21'h00555, 16'h00AA);
    wr_cyc(21'h002AA, 16'h0055);
    wr_cyc(21'h00555, 16'h0040);
    wr_cyc(21'h00555, 16'h00AA);
    wr_cyc(21'h002AA, 16'h0054);
    wr_cyc(21'h00555, 16'h00A0);
    wr_cyc(21'h00300, 16'h0022);
    wr_cyc(21'h00555, 16'h00AA);
    wr_cyc(21'h002AA, 16'h0055);
    wr_cyc(21'h00556, 16'h00A0);
    wr_cyc(21'h00300, 16'h0022);
    drain();

    // R7 F0 mid-sequence and in place of program data
    wr_cyc(21'h00555, 16'h00AA);
    wr_cyc(21'h002AA, 16'h0055);
    wr_cyc(21'h12345, 16'h00F0);
    wr_cyc(21'h00555, 16'h00A0);
    wr_cyc(21'h00300, 16'h0022);
    cmd_word(8'hA0);
    wr_cyc(21'h00400, 16'h00F0);
    wr_cyc(21'h00400, 16'h0033);
    drain();

    // R6 identification reads
    cmd_word(8'h90);
    check(autosel == 1'b1, "R6 autosel set", autosel, 1);
    rd_addr = 21'h00000; #1;
    check(rd_data == 16'h0001, "R6 manufacturer", rd_data, 16'h0001);
    rd_addr = 21'h00001; #1;
    check(rd_data == 16'h22DA, "R6 device", rd_data, 16'h22DA);
    rd_addr = {1'b0, 8'd5, 12'h002}; #1;
    check(rd_data == 16'h0001, "R6 protected sector", rd_data, 1);
    rd_addr = {1'b0, 8'd6, 12'h002}; #1;
    check(rd_data == 16'h0000, "R6 unprotected sector", rd_data, 0);
    rd_addr = 21'h00003; #1;
    check(rd_data == 16'h0000, "R6 other offset", rd_data, 0);
    byte_m = 1'b1;
    rd_addr = 21'h00002; #1;
    check(rd_data == 16'h00DA, "R6 byte device low", rd_data, 16'h00DA);
    rd_addr = 21'h00003; #1;
    check(rd_data == 16'h0022, "R6 byte device high", rd_data, 16'h0022);
    byte_m = 1'b0;
    // R7 other writes ignored while identifying
    cmd_word(8'hA0);
    wr_cyc(21'h00010, 16'h0044);
    check(autosel == 1'b1, "R7 autosel held", autosel, 1);
    wr_cyc(21'h00000, 16'h00F0);
    check(autosel == 1'b0, "R7 autosel cleared", autosel, 0);
    rd_addr = 21'h00001; #1;
    check(rd_data == 16'h0000, "R6 array mode rd_data", rd_data, 0);
    drain();

    // R8 bypass
    cmd_word(8'h20);
    check(bypass == 1'b1, "R8 bypass set", bypass, 1);
    wr_cyc(21'h00000, 16'h00A0);
    expect_ev(1, 21'h0ABCD, 16'h4242, '0);
    wr_cyc(21'h0ABCD, 16'h4242);
    wr_cyc(21'h00000, 16'h00A0);
    expect_ev(1, 21'h00010, 16'h0909, '0);
    wr_cyc(21'h00010, 16'h0909);
    drain();
    cmd_word(8'h90);
    check(autosel == 1'b0, "R8 unlock ignored in bypass", autosel, 0);
    wr_cyc(21'h00000, 16'h00F0);
    check(bypass == 1'b1, "R7 F0 keeps bypass", bypass, 1);
    wr_cyc(21'h00000, 16'h0090);
    wr_cyc(21'h00000, 16'h0001);
    check(bypass == 1'b1, "R8 90 non-00 keeps bypass", bypass, 1);
    wr_cyc(21'h00000, 16'h0090);
    wr_cyc(21'h00000, 16'h0000);
    check(bypass == 1'b0, "R8 bypass cleared", bypass, 0);
    wr_cyc(21'h00000, 16'h00A0);
    wr_cyc(21'h00020, 16'h0077);
    drain();

    // R9 suspend / resume
    wr_cyc(21'h00000, 16'h00B0);
    wr_cyc(21'h00000, 16'h0030);
    drain();
    busy = 1'b1;
    expect_ev(4, '0, '0, '0);
    wr_cyc(21'h1F00F, 16'h00B0);
    expect_ev(5, '0, '0, '0);
    wr_cyc(21'h00001, 16'h0030);
    drain();
    busy = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule